// File: doc/BRIEF.md
# Inter-layer test data serial link

This block moves a word of parallel decompressor tap bits from one die of a stacked device to the die above it over fewer vertical wires than there are bits. It relies on a fast clock that runs an integer number of times faster than scan shifting. The sending side latches the whole tap word on a scan strobe. It then drives one slice of the word onto the wires in each fast cycle, so that every slice has been sent by the time the next scan cycle begins.

The receiving side collects the slices in a shift register clocked by the same fast clock. Once the last slice has arrived, it presents the rebuilt word to the downstream decompressor with the bits in their original positions. The number of wires is the tap width divided by the clock ratio. With the wire count held fixed, a higher ratio instead raises the number of bits carried per scan cycle.

Both sides run in one fast clock domain and share the scan strobe. Each side has its own phase counter, as it would in a real stack.

Top module: `elev_serdes_link`

## Requirements
- R1: The number of vertical wires is TAP_W / RATIO. Elaboration is refused unless RATIO divides TAP_W evenly.
- R2: On a fast clock edge where scan_stb_i is high, the sender captures tap_i. Changes on tap_i at any other time have no effect on what is sent.
- R3: In the k-th fast cycle after a capture edge (k = 0 … RATIO-1), elev_o carries bits k·W … k·W+W-1 of the captured word, where W is the wire count. Slice 0 appears in the cycle directly after the capture edge.
- R4: The phase counter returns to 0 on every strobe. Without a strobe it wraps from RATIO-1 to 0, so an idle link repeats the held word's slices in the same order.
- R5: Bit i of tap_o equals bit i of the captured word for every i, so the tap order is preserved end to end.
- R6: tap_o changes only on the fast edge that captures the last slice. That edge comes exactly RATIO fast cycles after the capture edge. At all other times tap_o holds its value.
- R7: During reset, and after reset until the first strobe has been followed by a full word, tap_o and elev_o are all zeros.
- R8: Once the first strobe has been seen, scan strobes arrive exactly every RATIO fast cycles, with each one in the counter's last phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, RATIO times the scan shift rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_stb_i | input | 1 | One fast-cycle pulse per scan shift cycle |
| tap_i | input | TAP_W | Parallel tap bits from the sending decompressor |
| elev_o | output | TAP_W/RATIO | Vertical wires, one slice per fast cycle |
| tap_o | output | TAP_W | Rebuilt tap word for the receiving decompressor |

## Verification
The bench builds the link with 8 tap bits and a ratio of 4, which gives 2 wires. At this size all 256 tap words can be sent back to back. Each slice is checked on the wires in its own phase, and each rebuilt word is checked at its exact arrival edge and while it is held. Tap inputs are scrambled during every serialization window to show that they are ignored. A final idle stretch with no strobe exercises the counter wrap and the repeated reload of the same word.

// File: rtl/elev_link_pkg.sv
package elev_link_pkg;
  function automatic int unsigned phase_width(int unsigned ratio);
    return (ratio < 2) ? 1 : $clog2(ratio);
  endfunction
endpackage

// File: rtl/elev_phase_ctr.sv
module elev_phase_ctr #(
  parameter int unsigned RATIO = 4,
  parameter int unsigned PW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scan_stb_i,
  output logic [PW-1:0] phase_o
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        phase_q <= '0;
    else if (scan_stb_i || phase_q == LAST) phase_q <= '0;
    else                                phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/elev_ser.sv
module elev_ser #(
  parameter int unsigned TAP_W  = 8,
  parameter int unsigned WIRE_W = 2,
  parameter int unsigned RATIO  = 4,
  parameter int unsigned PW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_stb_i,
  input  logic [TAP_W-1:0]  tap_i,
  input  logic [PW-1:0]     phase_i,
  output logic [WIRE_W-1:0] wire_o
);
  logic [TAP_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (scan_stb_i) hold_q <= tap_i;
  end

  // slice select: phase k drives bits k*W .. k*W+W-1
  always_comb begin
    wire_o = '0;
    for (int g = 0; g < RATIO; g++)
      if (phase_i == PW'(g)) wire_o = hold_q[g*WIRE_W +: WIRE_W];
  end

  assert_hold_ignores_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_stb_i |=> $stable(hold_q));

  assert_first_slice_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_stb_i |=> wire_o == $past(tap_i[WIRE_W-1:0]));
endmodule

// File: rtl/elev_deser.sv
module elev_deser #(
  parameter int unsigned TAP_W  = 8,
  parameter int unsigned WIRE_W = 2,
  parameter int unsigned RATIO  = 4,
  parameter int unsigned PW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_stb_i,
  input  logic [PW-1:0]     phase_i,
  input  logic [WIRE_W-1:0] wire_i,
  output logic [TAP_W-1:0]  tap_o
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [TAP_W-1:0] sh_q, sh_d, tap_q;
  logic             armed_q;
  logic             load;

  // newest slice enters at the top; after RATIO shifts slice 0 sits at the bottom
  if (TAP_W == WIRE_W) begin : g_single
    assign sh_d = wire_i;
  end else begin : g_shift
    assign sh_d = {wire_i, sh_q[TAP_W-1:WIRE_W]};
  end

  assign load = armed_q && (phase_i == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      tap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      if (scan_stb_i) armed_q <= 1'b1;
      if (load)       tap_q   <= sh_d;
    end
  end

  assign tap_o = tap_q;

  assert_out_only_on_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_q) |-> $past(phase_i == LAST));

  assert_quiet_until_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> tap_q == '0);

  assert_strobe_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && scan_stb_i) |-> phase_i == LAST);
endmodule

// File: rtl/elev_serdes_link.sv
module elev_serdes_link #(
  parameter int unsigned TAP_W = 8,
  parameter int unsigned RATIO = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scan_stb_i,
  input  logic [TAP_W-1:0]         tap_i,
  output logic [TAP_W/RATIO-1:0]   elev_o,
  output logic [TAP_W-1:0]         tap_o
);
  localparam int unsigned WIRE_W = TAP_W / RATIO;
  localparam int unsigned PW     = elev_link_pkg::phase_width(RATIO);

  // R1: wire count must be an exact division
  if (RATIO == 0 || (TAP_W % RATIO) != 0) begin : g_bad_cfg
    $error("elev_serdes_link: TAP_W must be a multiple of RATIO");
  end

  logic [PW-1:0] tx_phase, rx_phase;

  elev_phase_ctr #(.RATIO(RATIO), .PW(PW)) u_tx_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_stb_i(scan_stb_i), .phase_o(tx_phase));

  elev_phase_ctr #(.RATIO(RATIO), .PW(PW)) u_rx_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_stb_i(scan_stb_i), .phase_o(rx_phase));

  elev_ser #(.TAP_W(TAP_W), .WIRE_W(WIRE_W), .RATIO(RATIO), .PW(PW)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_stb_i(scan_stb_i),
    .tap_i(tap_i), .phase_i(tx_phase), .wire_o(elev_o));

  elev_deser #(.TAP_W(TAP_W), .WIRE_W(WIRE_W), .RATIO(RATIO), .PW(PW)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_stb_i(scan_stb_i),
    .phase_i(rx_phase), .wire_i(elev_o), .tap_o(tap_o));
endmodule

// File: tb/sim_elev_serdes_link.sv
module sim_elev_serdes_link;
  localparam int TAP_W  = 8;
  localparam int RATIO  = 4;
  localparam int WIRE_W = TAP_W / RATIO;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              scan_stb = 1'b0;
  logic [TAP_W-1:0]  tap_in = '0;
  logic [WIRE_W-1:0] elev;
  logic [TAP_W-1:0]  tap_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  elev_serdes_link #(.TAP_W(TAP_W), .RATIO(RATIO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scan_stb_i(scan_stb),
    .tap_i(tap_in), .elev_o(elev), .tap_o(tap_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic [TAP_W-1:0] cur, prev;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk(tap_out == '0, "R7 reset tap_o", tap_out, 0);
    chk(elev == '0, "R7 reset elev_o", elev, 0);
    rst_ni = 1'b1;
    // R7: no strobe yet, inputs moving, outputs stay zero
    for (int i = 0; i < 6; i++) begin
      tap_in = TAP_W'(8'hF0 + i);
      @(negedge clk);
      chk(tap_out == '0, "R7 pre-strobe tap_o", tap_out, 0);
      chk(elev == '0, "R7 pre-strobe elev_o", elev, 0);
    end
    // exhaustive sweep: word 256 is a final flush word
    prev = '0;
    cur  = '0;
    scan_stb = 1'b1;
    tap_in = cur;
    for (int w = 0; w <= 256; w++) begin
      cur = (w < 256) ? TAP_W'(w) : TAP_W'(8'h3C);
      for (int k = 0; k < RATIO; k++) begin
        @(negedge clk);
        // R3 slice per phase; R2 since tap_in was scrambled after capture
        chk(elev == cur[k*WIRE_W +: WIRE_W], "R3/R2 slice", elev, cur[k*WIRE_W +: WIRE_W]);
        if (k == 0) chk(tap_out == prev, "R5 rebuilt word at latency", tap_out, prev);
        else        chk(tap_out == prev, "R6 output held", tap_out, prev);
        if (k == RATIO-1 && w < 256) begin
          scan_stb = 1'b1;
          tap_in = (w + 1 < 256) ? TAP_W'(w + 1) : TAP_W'(8'h3C);
        end else begin
          scan_stb = 1'b0;
          tap_in = ~cur ^ TAP_W'(k * 8'h35);
        end
      end
      prev = cur;
    end
    // R4: idle link wraps and repeats the held word's slices
    for (int j = 0; j < 2*RATIO; j++) begin
      @(negedge clk);
      chk(elev == cur[(j % RATIO)*WIRE_W +: WIRE_W], "R4 wrap slice", elev,
          cur[(j % RATIO)*WIRE_W +: WIRE_W]);
      chk(tap_out == cur, "R5/R6 idle reload", tap_out, cur);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule